// File: doc/BRIEF.md
# PLL Lock and Clock Status Register

This block holds the status word of a clock synthesizer. It watches a raw lock indicator that arrives asynchronously from the PLL. It keeps a sticky loss-of-lock flag, which software clears by writing a one to the flag's bit. It also keeps a live loss-of-clock bit, which follows a fault detector. The block drives a 32-bit read-back word and a loss-of-lock interrupt request. That request is gated by an enable input.

Some lock drops are expected, and the flag ignores them. A drop forced by reset does not set the flag. A drop that follows a divider or multiplier reprogramming does not set the flag: detection stays masked until the synchronized lock is seen rising again. A drop seen in bypass mode does not set the flag either. Entering bypass leaves a flag that is already set untouched.

The block has no streaming data path. Every pin is plain control or status, and the write port is a single-cycle strobe with no back-pressure.

Top module: `pll_stat_reg`

## Requirements
- R1: After reset, rd_data reads 0 and lol_irq is 0.
- R2: A 1-to-0 transition of the lock input, after the two-flop synchronizer, sets the loss-of-lock flag at rd_data bit 22. This happens in normal mode, with no masking in force. The flag is visible by the third rising edge after lock_raw falls.
- R3: The loss-of-lock flag stays set when lock returns, until it is cleared.
- R4: A write strobe with wr_data bit 22 = 1 clears the flag at that edge. A write with bit 22 = 0 leaves the flag unchanged, whatever the other data bits hold.
- R5: A lock drop caused by reset (lock low while rst_n is low or released low) does not set the flag.
- R6: After a cfg_wr pulse, lock drops do not set the flag until the synchronized lock has risen again. A later drop then sets it.
- R7: A lock drop while bypass = 1 does not set the flag. Raising bypass does not clear a flag that is already set.
- R8: rd_data bit 23 equals loc_det & loc_en & ~bypass, registered with one cycle of latency. It clears on its own when the condition goes away.
- R9: rd_data bits 0–21 and 24–31 always read 0.
- R10: lol_irq = loss-of-lock flag & irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw | input | 1 | Raw asynchronous lock indicator from the PLL |
| loc_det | input | 1 | Loss-of-clock detector output |
| loc_en | input | 1 | Enables reporting of loss-of-clock |
| bypass | input | 1 | 1 while the synthesizer is bypassed |
| cfg_wr | input | 1 | Pulse: divider/multiplier/mode settings were rewritten |
| wr_en | input | 1 | Status-word write strobe |
| wr_data | input | 32 | Write data; bit 22 = 1 clears the loss-of-lock flag |
| irq_en | input | 1 | Loss-of-lock interrupt enable |
| rd_data | output | 32 | Status word: bit 23 loss-of-clock, bit 22 loss-of-lock |
| lol_irq | output | 1 | Loss-of-lock interrupt request |

## Verification
The flag path is tried with every combination of bypass and a preceding cfg_wr around a lock drop. This separates real drops from the three kinds of suppressed drop. A second drop after relock shows that the mask releases rather than sticking. The live bit is swept over all eight combinations of detector, enable and bypass, and each combination is then withdrawn so that a latched value is caught. Writes with only bit 22, with every bit except 22, and with zero tell the clear from a write-anything-clears fault. Each interrupt-enable value is tried with the flag set and with the flag clear.

// File: rtl/pll_stat_pkg.sv
package pll_stat_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LOL_POS = 22;
  localparam int unsigned LOC_POS = 23;
  localparam int unsigned SYNC_N  = 2;
endpackage

// File: rtl/lock_edge_sync.sv
module lock_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync_q,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign sync_q = chain[STAGES-1];
  assign fall   = prev & ~sync_q;
  assign rise   = ~prev & sync_q;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && rise)); // R2
endmodule

// File: rtl/lol_flag.sv
module lol_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_fall,
  input  logic lock_rise,
  input  logic cfg_wr,
  input  logic bypass,
  input  logic clr,
  output logic flag
);
  logic mask_q;
  logic set_evt;

  // Mask starts armed out of reset and re-arms on a reprogramming pulse;
  // a fresh rising edge of the synchronized lock releases it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= 1'b1;
    else if (cfg_wr)    mask_q <= 1'b1;
    else if (lock_rise) mask_q <= 1'b0;
  end

  assign set_evt = lock_fall & ~mask_q & ~bypass & ~cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  AST_STICKY:      assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R3
  AST_W1C:         assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !lock_fall) |=> !flag); // R4
  AST_MASK_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !flag) |=> !flag); // R6
  AST_BYPASS_SET:  assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !flag) |=> !flag); // R7
  AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && flag && !clr) |=> flag); // R7
endmodule

// File: rtl/clk_fault_stat.sv
module clk_fault_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_det,
  input  logic loc_en,
  input  logic bypass,
  output logic loc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loc_q <= 1'b0;
    else        loc_q <= loc_det & loc_en & ~bypass;
  end

  AST_LOC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass || !loc_en || !loc_det) |=> !loc_q); // R8
endmodule

// File: rtl/pll_stat_reg.sv
module pll_stat_reg
  import pll_stat_pkg::*;
#(
  parameter int unsigned W       = WORD_W,
  parameter int unsigned LOL_BIT = LOL_POS,
  parameter int unsigned LOC_BIT = LOC_POS,
  parameter int unsigned SYNC    = SYNC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_raw,
  input  logic         loc_det,
  input  logic         loc_en,
  input  logic         bypass,
  input  logic         cfg_wr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         irq_en,
  output logic [W-1:0] rd_data,
  output logic         lol_irq
);
  logic lock_s, lock_fall, lock_rise;
  logic lol, loc, lol_clr;

  lock_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(lock_raw),
    .sync_q(lock_s), .fall(lock_fall), .rise(lock_rise)
  );

  assign lol_clr = wr_en & wr_data[LOL_BIT];

  lol_flag u_lol (
    .clk(clk), .rst_n(rst_n), .lock_fall(lock_fall), .lock_rise(lock_rise),
    .cfg_wr(cfg_wr), .bypass(bypass), .clr(lol_clr), .flag(lol)
  );

  clk_fault_stat u_loc (
    .clk(clk), .rst_n(rst_n), .loc_det(loc_det), .loc_en(loc_en),
    .bypass(bypass), .loc_q(loc)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[LOL_BIT] = lol;
    rd_data[LOC_BIT] = loc;
  end

  assign lol_irq = lol & irq_en;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    lol_irq |-> rd_data[LOL_BIT]); // R10
  AST_LOCK_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rise |-> lock_s); // R6
endmodule

// File: tb/sim_pll_stat_reg.sv
module sim_pll_stat_reg;
  logic        clk = 0, rst_n = 0;
  logic        lock_raw = 0, loc_det = 0, loc_en = 0, bypass = 0, cfg_wr = 0;
  logic        wr_en = 0, irq_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        lol_irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pll_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .loc_det(loc_det),
    .loc_en(loc_en), .bypass(bypass), .cfg_wr(cfg_wr), .wr_en(wr_en),
    .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd_data), .lol_irq(lol_irq)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; step(1); wr_en = 0; wr_data = 0;
  endtask

  task automatic relock();
    lock_raw = 1; step(6);
  endtask

  initial begin
    fork
      begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog expired");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    lock_raw = 1;
    step(3);
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'b0, lol_irq}, 32'h0);
    rst_n = 1;
    step(6); // rise releases the reset mask

    // R2: plain drop sets after sync; R3 sticky across relock
    lock_raw = 0; step(1);
    chk("R2 not before sync", {31'b0, rd_data[22]}, 0);
    step(4);
    chk("R2 set", rd_data, 32'h0040_0000);
    relock();
    chk("R3 sticky", {31'b0, rd_data[22]}, 1);

    // R10 irq gating with flag set
    irq_en = 1; #1;
    chk("R10 irq on", {31'b0, lol_irq}, 1);
    irq_en = 0; #1;
    chk("R10 irq off", {31'b0, lol_irq}, 0);

    // R4: writes without bit 22 leave it; bit 22 clears
    wr(32'h0);
    chk("R4 write zero", {31'b0, rd_data[22]}, 1);
    wr(32'hFFBF_FFFF);
    chk("R4 other bits", {31'b0, rd_data[22]}, 1);
    chk("R9 reserved", rd_data & 32'hFF3F_FFFF, 0);
    wr(32'h0040_0000);
    chk("R4 w1c", {31'b0, rd_data[22]}, 0);
    irq_en = 1; #1;
    chk("R10 irq flag clear", {31'b0, lol_irq}, 0);
    irq_en = 0;

    // R6/R7 sweep: bypass x cfg before drop
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 2; c++) begin
        relock();
        wr(32'h0040_0000);
        if (c) begin cfg_wr = 1; step(1); cfg_wr = 0; end
        bypass = b[0];
        step(1);
        lock_raw = 0; step(6);
        chk((b != 0) ? "R7 sweep" : "R6 sweep", {31'b0, rd_data[22]},
            {31'b0, (b == 0 && c == 0)});
        bypass = 0;
      end
    end

    // R6: mask released by relock, next drop sets
    relock();
    wr(32'h0040_0000);
    cfg_wr = 1; step(1); cfg_wr = 0;
    lock_raw = 0; step(6);
    chk("R6 masked", {31'b0, rd_data[22]}, 0);
    relock();
    lock_raw = 0; step(6);
    chk("R6 released", {31'b0, rd_data[22]}, 1);

    // R7: bypass keeps existing flag
    bypass = 1; step(4);
    chk("R7 bypass keeps", {31'b0, rd_data[22]}, 1);
    bypass = 0;
    relock();
    wr(32'h0040_0000);

    // R5: drop during reset
    rst_n = 0; lock_raw = 0; step(2);
    rst_n = 1; step(6);
    chk("R5 reset drop", rd_data, 0);
    relock();
    chk("R5 after relock", rd_data, 0);

    // R8 sweep: 8 combos, then withdraw
    for (int k = 0; k < 8; k++) begin
      loc_det = k[0]; loc_en = k[1]; bypass = k[2];
      step(1);
      chk("R8 loc", {31'b0, rd_data[23]}, {31'b0, (k[0] & k[1] & ~k[2])});
      chk("R9 reserved", rd_data & 32'hFF3F_FFFF, 0);
      loc_det = 0; step(1);
      chk("R8 self clear", {31'b0, rd_data[23]}, 0);
    end
    bypass = 0; loc_en = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule